// File: doc/BRIEF.md
# Serial-Command AHB Debug Master

This block gives an external host access to the on-chip AHB fabric. The host sends a single-word read or write command over a slow clocked serial link. The block brings the link into the bus clock domain and decodes the frame. It then competes for the shared bus like any other master: it raises a request, waits for the arbiter's grant and for ownership to pass to it at a transfer boundary, and runs one ordinary single transfer. When the transfer is over it releases the bus.

For a read, the block latches the data that the slave returns and holds it together with an error flag. The host then clocks this response out serially. The block sits next to the CPU on the arbitrated bus, so it can reach memory and peripherals whether the CPU is running or stalled. The host serial clock must run at least four times slower than the bus clock.

Top module: `dbg_ahb_master`

## Requirements
- R1: While `sfs_i` is high, a command frame of 66 bits is shifted in on rising edges of `sclk_i`, MSB first. Bit 65 selects the direction (1 is a write, 0 is a read), bit 64 is reserved, bits 63:32 hold the address and bits 31:0 hold the write data. The bus request rises only after the 66th bit has been taken.
- R2: The block drives a NONSEQ transfer only while `hmaster_i` equals its MASTER_ID, which happens after a grant.
- R3: A CPU transfer that is still in progress, seen as `hready_i` low, delays the takeover. While `hready_i` is low, a pending address phase holds its address and control signals.
- R4: `htrans_o` is NONSEQ (2'b10) for the single transfer and IDLE (2'b00) at every other time. `hsize_o` is word (3'b010) and `hburst_o` is SINGLE (3'b000). A read drives the command address with `hwrite_o` low.
- R5: Read data is taken from `hrdata_i` only in the data-phase cycle in which `hready_i` is high, so any number of slave wait states is honoured.
- R6: A write drives `hwrite_o` high in the address phase. `hwdata_o` carries the command's write data in the data phase that follows.
- R7: `hbusreq_o` stays high until the data phase completes and then drops. After a write, `busy_o` returns low.
- R8: The read response is 33 bits on `sdo_o`: the data MSB first, then the error flag. The first bit is presented before the first clock. The output advances on each rising edge of `sclk_i` while `sfs_i` is low.
- R9: An ERROR response (`hresp_i` = 2'b01) sets the response error flag. The transfer is not retried.
- R10: `busy_o` is high from the moment a command is accepted until its transfer has finished (for a write) or its response has been fully shifted out (for a read). A command that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| sdi_i | input | 1 | Host serial command data |
| sfs_i | input | 1 | Frame select: high while a command is shifted in |
| sdo_o | output | 1 | Serial response data |
| busy_o | output | 1 | Command in progress |
| hbusreq_o | output | 1 | Bus request to the arbiter |
| hgrant_i | input | 1 | Grant from the arbiter |
| hmaster_i | input | MASTER_W | Current bus owner |
| hready_i | input | 1 | Transfer done / bus ready |
| hresp_i | input | 2 | Slave response |
| hrdata_i | input | DATA_W | Read data |
| htrans_o | output | 2 | Transfer type |
| haddr_o | output | ADDR_W | Address |
| hwrite_o | output | 1 | Write select |
| hsize_o | output | 3 | Transfer size |
| hburst_o | output | 3 | Burst type |
| hwdata_o | output | DATA_W | Write data |

## Verification
The ownership and hold properties trust the arbiter in two ways. It keeps the grant and `hmaster_i` fixed while the request is high, and it moves ownership only on a cycle with `hready_i` high. The bench arbiter registers the grant one cycle after the request and updates the owner only when `hready_i` is high. The bench slave drives a two-cycle ERROR and wait states only inside a data phase that the block started.

The serial properties assume the host changes `sdi_i` and `sfs_i` while `sclk_i` is low. They also assume each phase of `sclk_i` lasts several bus clocks. The bench host holds each phase for six cycles and changes the data only after the clock has fallen.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } dbg_state_e;

  localparam logic [1:0] TR_IDLE      = 2'b00;
  localparam logic [1:0] TR_NONSEQ    = 2'b10;
  localparam logic [2:0] SIZE_WORD    = 3'b010;
  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [1:0] RESP_ERR     = 2'b01;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dbg_serial_rx.sv
module dbg_serial_rx #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sfs_i,
  output logic              rise_o,
  output logic              fs_o,
  output logic              valid_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CMD_W = 2 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);

  logic [2:0]       s_q;
  logic             sclk_d;
  logic [CMD_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  dbg_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdi_i, sfs_i}),
    .q_o   (s_q)
  );

  assign rise_o = s_q[2] & ~sclk_d;
  assign fs_o   = s_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      sclk_d  <= s_q[2];
      valid_o <= 1'b0;
      if (!fs_o) begin
        cnt_q <= '0;
      end else if (rise_o && cnt_q < FULL) begin
        sh_q  <= {sh_q[CMD_W-2:0], s_q[1]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) valid_o <= 1'b1;
      end
    end
  end

  assign rw_o   = sh_q[CMD_W-1];
  assign addr_o = sh_q[DATA_W +: ADDR_W];
  assign data_o = sh_q[DATA_W-1:0];

  assert_cmd_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/dbg_serial_tx.sv
module dbg_serial_tx #(
  parameter int RSP_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RSP_W-1:0] data_i,
  input  logic             shift_i,
  output logic             sdo_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(RSP_W + 1);

  logic [RSP_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= CNT_W'(RSP_W);
    end else if (shift_i && busy_o) begin
      sh_q  <= {sh_q[RSP_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sdo_o  = sh_q[RSP_W-1];
  assign busy_o = cnt_q != '0;

  assert_sdo_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !shift_i |=> $stable(sdo_o));
endmodule

// File: rtl/dbg_ahb_master.sv
module dbg_ahb_master
  import dbg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MASTER_W  = 4,
  parameter int MASTER_ID = 1
) (
  input  logic                hclk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                sdi_i,
  input  logic                sfs_i,
  output logic                sdo_o,
  output logic                busy_o,
  output logic                hbusreq_o,
  input  logic                hgrant_i,
  input  logic [MASTER_W-1:0] hmaster_i,
  input  logic                hready_i,
  input  logic [1:0]          hresp_i,
  input  logic [DATA_W-1:0]   hrdata_i,
  output logic [1:0]          htrans_o,
  output logic [ADDR_W-1:0]   haddr_o,
  output logic                hwrite_o,
  output logic [2:0]          hsize_o,
  output logic [2:0]          hburst_o,
  output logic [DATA_W-1:0]   hwdata_o
);
  localparam int RSP_W = DATA_W + 1;
  localparam logic [MASTER_W-1:0] MY_ID = MASTER_W'(MASTER_ID);

  logic              rx_rise, rx_fs, rx_valid, rx_rw;
  logic [ADDR_W-1:0] rx_addr;
  logic [DATA_W-1:0] rx_data;
  logic              tx_load, tx_shift, tx_busy;
  logic              owned;

  dbg_state_e        state_q, state_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  dbg_serial_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i  (hclk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdi_i  (sdi_i),
    .sfs_i  (sfs_i),
    .rise_o (rx_rise),
    .fs_o   (rx_fs),
    .valid_o(rx_valid),
    .rw_o   (rx_rw),
    .addr_o (rx_addr),
    .data_o (rx_data)
  );

  assign owned    = hgrant_i && (hmaster_i == MY_ID);
  assign tx_load  = (state_q == ST_DATA) && hready_i && !wr_q;
  assign tx_shift = (state_q == ST_RESP) && rx_rise && !rx_fs;

  dbg_serial_tx #(.RSP_W(RSP_W)) u_tx (
    .clk_i  (hclk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i ({hrdata_i, hresp_i == RESP_ERR}),
    .shift_i(tx_shift),
    .sdo_o  (sdo_o),
    .busy_o (tx_busy)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rx_valid) state_d = ST_REQ;
      ST_REQ:  if (owned) state_d = ST_ADDR;
      ST_ADDR: if (hready_i) state_d = ST_DATA;
      ST_DATA: if (hready_i) state_d = wr_q ? ST_IDLE : ST_RESP;
      ST_RESP: if (!tx_busy) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge hclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && rx_valid) begin
        wr_q    <= rx_rw;
        addr_q  <= rx_addr;
        wdata_q <= rx_data;
      end
    end
  end

  assign busy_o    = state_q != ST_IDLE;
  assign hbusreq_o = (state_q == ST_REQ) || (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign htrans_o  = (state_q == ST_ADDR) ? TR_NONSEQ : TR_IDLE;
  assign haddr_o   = addr_q;
  assign hwrite_o  = wr_q;
  assign hwdata_o  = wdata_q;
  assign hsize_o   = SIZE_WORD;
  assign hburst_o  = BURST_SINGLE;

  assert_req_after_cmd_R1: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    $rose(hbusreq_o) |-> $past(rx_valid));

  assert_own_before_drive_R2: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    htrans_o == TR_NONSEQ |-> hmaster_i == MY_ID);

  assert_addr_hold_R3: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    htrans_o == TR_NONSEQ && !hready_i |=>
      htrans_o == TR_NONSEQ && $stable(haddr_o) && $stable(hwrite_o));

  assert_release_R7: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    $fell(hbusreq_o) |-> $past(hready_i));

  assert_no_retry_R9: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    state_q == ST_DATA && hready_i |=> htrans_o == TR_IDLE);

  assert_ignore_busy_R10: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    busy_o && rx_valid |=> $stable(addr_q) && $stable(wr_q) && $stable(wdata_q));
endmodule

// File: tb/dbg_ahb_master_test.sv
module dbg_ahb_master_test;
  localparam int MID = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sclk, sdi, sfs;
  logic        sdo, busy, hbusreq, hwrite;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic [31:0] haddr, hwdata;
  logic        hgrant, hready;
  logic [3:0]  hmaster;
  logic [1:0]  hresp;
  logic [31:0] hrdata;

  dbg_ahb_master #(.MASTER_ID(MID)) uut (
    .hclk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sfs_i(sfs),
    .sdo_o(sdo), .busy_o(busy), .hbusreq_o(hbusreq), .hgrant_i(hgrant),
    .hmaster_i(hmaster), .hready_i(hready), .hresp_i(hresp), .hrdata_i(hrdata),
    .htrans_o(htrans), .haddr_o(haddr), .hwrite_o(hwrite), .hsize_o(hsize),
    .hburst_o(hburst), .hwdata_o(hwdata)
  );

  // arbiter, CPU stall and slave model
  int          cyc;
  int          stall_end;
  int          wait_n;
  logic        pend, pw, perr, estage;
  logic [31:0] pa;
  int          wcnt;
  logic [31:0] mem [16];

  always_comb begin
    if (pend) begin
      if (wcnt != 0)  hready = 1'b0;
      else if (perr)  hready = estage;
      else            hready = 1'b1;
    end else begin
      hready = (cyc >= stall_end);
    end
    hresp  = (pend && perr && wcnt == 0) ? 2'b01 : 2'b00;
    hrdata = pend ? mem[pa[5:2]] : 32'h0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; hgrant <= 1'b0; hmaster <= 4'd0;
      pend <= 1'b0; pw <= 1'b0; perr <= 1'b0; estage <= 1'b0; pa <= '0; wcnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
    end else begin
      cyc    <= cyc + 1;
      hgrant <= hbusreq;
      if (hready) hmaster <= hgrant ? 4'(MID) : 4'd0;
      if (pend) begin
        if (wcnt != 0) wcnt <= wcnt - 1;
        else if (perr && !estage) estage <= 1'b1;
        else begin
          pend <= 1'b0;
          if (pw && !perr) mem[pa[5:2]] <= hwdata;
        end
      end
      if (hready && htrans == 2'b10) begin
        pend <= 1'b1; pa <= haddr; pw <= hwrite;
        perr <= (haddr[31:28] == 4'hE); wcnt <= wait_n; estage <= 1'b0;
      end
    end
  end

  // scoreboard
  logic [64:0] exp_q [$];
  logic [64:0] item;
  int          mon_chk, mon_fail, req_rises;
  logic        req_prev, wd_pend;
  logic [31:0] wd_exp;

  always @(negedge clk) begin
    if (!rst_n) begin
      req_prev = 1'b0; wd_pend = 1'b0;
    end else begin
      if (hbusreq && !req_prev) req_rises++;
      req_prev = hbusreq;
      if (wd_pend && hready) begin
        mon_chk++;
        if (hwdata !== wd_exp) begin
          mon_fail++;
          $display("FAIL R6 hwdata: actual %h expected %h", hwdata, wd_exp);
        end
        wd_pend = 1'b0;
      end
      if (htrans == 2'b10) begin
        mon_chk++;
        if (hmaster != 4'(MID)) begin
          mon_fail++;
          $display("FAIL R2 owner: actual %0d expected %0d", hmaster, MID);
        end
        mon_chk++;
        if (cyc < stall_end) begin
          mon_fail++;
          $display("FAIL R3 takeover during CPU transfer: actual cycle %0d expected >= %0d", cyc, stall_end);
        end
        if (hready) begin
          mon_chk++;
          if (exp_q.size() == 0) begin
            mon_fail++;
            $display("FAIL R10 unexpected transfer: actual addr %h expected none", haddr);
          end else begin
            item = exp_q.pop_front();
            if ({hwrite, haddr, hsize, hburst} !== {item[64], item[63:32], 3'b010, 3'b000}) begin
              mon_fail++;
              $display("FAIL R4 address phase: actual %h expected %h",
                       {hwrite, haddr, hsize, hburst}, {item[64], item[63:32], 3'b010, 3'b000});
            end
            if (item[64]) begin
              wd_pend = 1'b1;
              wd_exp  = item[31:0];
            end
          end
        end
      end
    end
  end

  // driver side
  int   n_chk, n_fail, rises_before;
  logic done;

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_cmd(logic rw, logic [31:0] a, logic [31:0] d, logic push);
    logic [65:0] f;
    f = {rw, 1'b0, a, d};
    if (push) exp_q.push_back({rw, a, d});
    sfs = 1'b1;
    for (int i = 65; i >= 0; i--) begin
      sdi = f[i];
      wait_clk(6);
      if (i == 0) rises_before = req_rises;
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
    end
    wait_clk(6);
    sfs = 1'b0;
    sdi = 1'b0;
    wait_clk(2);
  endtask

  task automatic read_rsp(output logic [31:0] d, output logic e);
    logic [32:0] r;
    r = '0;
    for (int i = 0; i < 33; i++) begin
      r = {r[31:0], sdo};
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
      wait_clk(6);
    end
    wait_clk(6);
    d = r[32:1];
    e = r[0];
  endtask

  initial begin
    int   r0;
    logic [31:0] d;
    logic e;
    done = 1'b0; n_chk = 0; n_fail = 0; mon_chk = 0; mon_fail = 0; req_rises = 0;
    rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; sfs = 1'b0; wait_n = 0; stall_end = 0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    chk("R4 reset htrans", 64'(htrans), 64'(2'b00));
    chk("R7 reset hbusreq", 64'(hbusreq), 64'(0));
    chk("R10 reset busy", 64'(busy), 64'(0));
    chk("R8 reset sdo", 64'(sdo), 64'(0));

    // write, no wait states
    r0 = req_rises;
    shift_cmd(1'b1, 32'h0000_0010, 32'hA5A5_1234, 1'b1);
    chk("R1 no request before last bit", 64'(rises_before), 64'(r0));
    wait_clk(30);
    chk("R1 one request after frame", 64'(req_rises), 64'(r0 + 1));
    chk("R7 request dropped after write", 64'(hbusreq), 64'(0));
    chk("R7 busy low after write", 64'(busy), 64'(0));

    // read back with two wait states
    wait_n = 2;
    shift_cmd(1'b0, 32'h0000_0010, 32'hFFFF_FFFF, 1'b1);
    wait_clk(30);
    chk("R10 busy until response", 64'(busy), 64'(1));
    chk("R7 request dropped after read", 64'(hbusreq), 64'(0));
    read_rsp(d, e);
    chk("R5 R8 read data", 64'(d), 64'(32'hA5A5_1234));
    chk("R9 no error flag", 64'(e), 64'(0));
    chk("R10 busy low after response", 64'(busy), 64'(0));

    // CPU transfer in progress delays takeover
    wait_n = 0;
    stall_end = cyc + 830;
    shift_cmd(1'b1, 32'h0000_0024, 32'h1357_9BDF, 1'b1);
    wait_clk(10);
    chk("R3 request held during CPU transfer", 64'(hbusreq), 64'(1));
    chk("R3 owner still CPU", 64'(hmaster), 64'(0));
    wait_clk(60);
    chk("R7 released after stalled write", 64'(hbusreq), 64'(0));
    wait_n = 3;
    shift_cmd(1'b0, 32'h0000_0024, 32'h0, 1'b1);
    wait_clk(30);
    read_rsp(d, e);
    chk("R5 data after three wait states", 64'(d), 64'(32'h1357_9BDF));

    // error response
    wait_n = 1;
    shift_cmd(1'b0, 32'hE000_0040, 32'h0, 1'b1);
    wait_clk(30);
    read_rsp(d, e);
    chk("R9 error flag set", 64'(e), 64'(1));
    chk("R9 no retry", 64'(exp_q.size()), 64'(0));
    chk("R9 idle after error", 64'(busy), 64'(0));

    // command while busy is ignored
    wait_n = 0;
    shift_cmd(1'b1, 32'h0000_0030, 32'h0BAD_F00D, 1'b1);
    wait_clk(30);
    shift_cmd(1'b0, 32'h0000_0030, 32'h0, 1'b1);
    wait_clk(30);
    r0 = req_rises;
    shift_cmd(1'b1, 32'h0000_0030, 32'hDEAD_BEEF, 1'b0);
    wait_clk(30);
    chk("R10 still busy", 64'(busy), 64'(1));
    chk("R10 no request for ignored command", 64'(req_rises), 64'(r0));
    read_rsp(d, e);
    chk("R8 response after ignored command", 64'(d), 64'(32'h0BAD_F00D));
    shift_cmd(1'b0, 32'h0000_0030, 32'h0, 1'b1);
    wait_clk(30);
    read_rsp(d, e);
    chk("R10 ignored write left memory unchanged", 64'(d), 64'(32'h0BAD_F00D));
    chk("R4 all expected transfers seen", 64'(exp_q.size()), 64'(0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + mon_chk + 1, n_fail + mon_fail + 1);
      $finish;
    end
  end
endmodule